// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns one system clock into two single-cycle clock-enable strobes. The first paces a UART at its baud rate: each of its periods lasts sixteen times an integer count of system clocks. The second is a sampling tick for an infrared physical layer, and each of its periods lasts the integer count of system clocks with no factor. Most system clocks are not an exact multiple of the wanted rate, so each divider also has a 4-bit fractional correction. That correction adds one extra system clock to chosen periods, so the long-run average period reaches any ratio in steps of 1/16 of a clock.

Software programs four small registers through a simple write port: an integer count and a fractional count for each of the two dividers. A new value is held in a staging register and takes effect only when the current period ends, so no strobe is ever shortened or doubled. The infrared divider cannot divide by one. A write of zero to its integer count is refused, the previous count stays in force, and a sticky error flag rises until reset.

Top module: `fracBaudGen`

## Requirements
- R1: While reset is asserted and directly after it, both strobes are low and the error flag is low. With no writes, the UART period is (RST_UART_INT+1)×16 clocks and the IR period is RST_IR_INT+1 clocks (192 and 3 with the default parameters).
- R2: The UART strobe period is (N+1)×16 system clocks, plus one clock in periods chosen by the fraction. N is the UART integer field, written at address 0 in data bits [11:0].
- R3: The IR strobe period is (N+1) system clocks, plus one clock in periods chosen by the fraction. N is the IR integer field, written at address 2 in data bits [3:0].
- R4: Each divider keeps a 4-bit phase accumulator that is cleared by reset. At the start of every period after the first, the fraction F is added to the accumulator, and the period gets one extra clock exactly when that addition carries out of 4 bits. Over 16 periods this adds F clocks in total.
- R5: The fractional fields are taken from data bits [7:4] (UART fraction at address 1, IR fraction at address 3). Data bits [3:0] of a fraction write have no effect on the period lengths.
- R6: A write is staged at the clock edge where it is accepted. The period that is running finishes with its old length, and the next period that starts uses the new setting. The accumulator carries on without a restart.
- R7: A write to the IR integer field whose bits [3:0] are zero is refused and the previous IR count stays in force. The error flag then rises one clock edge later and stays high until reset.
- R8: Each strobe is high for exactly one system clock per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write enable, one write per cycle |
| wrAddr | input | 2 | Register select: 0 UART integer, 1 UART fraction, 2 IR integer, 3 IR fraction |
| wrData | input | 16 | Write data |
| uartTick | output | 1 | UART baud strobe, one clock wide |
| irTick | output | 1 | IR sampling strobe, one clock wide |
| cfgErr | output | 1 | Sticky flag: a zero IR integer count was refused |

## Verification
A write becomes visible in the staging registers one edge after it is driven. Its effect on a strobe appears only in the period that starts at the next boundary. The driver therefore writes only in the cycle right after a boundary and queues exactly one more period of the old length before the new lengths. The monitor samples both strobes on the falling clock edge, measures the interval between successive strobes, and compares it with the queued length. The first strobe after each reset only marks the start time. The error flag is sampled on the falling edge after the refused write's accepting edge.

// File: rtl/baudGenPkg.sv
package baudGenPkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 2;
  localparam int UART_INT_W = 12;
  localparam int IR_INT_W   = 4;
  localparam int FRAC_W     = 4;
  localparam int FRAC_LSB   = 4;
  localparam int UART_MUL_LOG2 = 4;
  localparam int IR_MUL_LOG2   = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_UART_INT  = 2'd0,
    REG_UART_FRAC = 2'd1,
    REG_IR_INT    = 2'd2,
    REG_IR_FRAC   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [UART_INT_W-1:0] uartInt;
    logic [FRAC_W-1:0]     uartFrac;
    logic [IR_INT_W-1:0]   irInt;
    logic [FRAC_W-1:0]     irFrac;
  } divCfg_t;
endpackage

// File: rtl/baudCtrl.sv
module baudCtrl
  import baudGenPkg::*;
#(
  parameter int RST_UART_INT = 11,
  parameter int RST_IR_INT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output divCfg_t           cfg,
  output logic              cfgErr
);
  logic [IR_INT_W-1:0] irField;
  logic [FRAC_W-1:0]   fracField;
  logic                irZero;

  always_comb begin
    irField   = wrData[IR_INT_W-1:0];
    fracField = wrData[FRAC_LSB +: FRAC_W];
    irZero    = (irField == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.uartInt  <= UART_INT_W'(RST_UART_INT);
      cfg.uartFrac <= '0;
      cfg.irInt    <= IR_INT_W'(RST_IR_INT);
      cfg.irFrac   <= '0;
      cfgErr       <= 1'b0;
    end else if (wrEn) begin
      case (regSel_e'(wrAddr))
        REG_UART_INT:  cfg.uartInt  <= wrData[UART_INT_W-1:0];
        REG_UART_FRAC: cfg.uartFrac <= fracField;
        REG_IR_INT: begin
          if (irZero) cfgErr    <= 1'b1;
          else        cfg.irInt <= irField;
        end
        REG_IR_FRAC:   cfg.irFrac   <= fracField;
        default: ;
      endcase
    end
  end

  AST_IR_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_IR_INT && wrData[IR_INT_W-1:0] == '0) |=> $stable(cfg.irInt)); // R7
  AST_IR_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_IR_INT && wrData[IR_INT_W-1:0] == '0) |=> cfgErr); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr); // R7
endmodule

// File: rtl/baudChan.sv
module baudChan #(
  parameter int INT_W    = 4,
  parameter int MUL_LOG2 = 0,
  parameter int FRAC_W   = 4,
  parameter int RST_INT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  intVal,
  input  logic [FRAC_W-1:0] fracVal,
  output logic              tick
);
  localparam int LEN_W = INT_W + MUL_LOG2 + 1;
  localparam logic [LEN_W-1:0] RST_LEN = LEN_W'((RST_INT + 1) << MUL_LOG2);

  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  lenReg;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic [LEN_W-1:0]  baseLen;
  logic [LEN_W-1:0]  nextLen;
  logic              atEnd;

  always_comb begin
    atEnd   = (cnt == lenReg - LEN_W'(1));
    sum     = {1'b0, acc} + {1'b0, fracVal};
    baseLen = (LEN_W'(intVal) + LEN_W'(1)) << MUL_LOG2;
    nextLen = baseLen + LEN_W'(sum[FRAC_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      lenReg <= RST_LEN;
      acc    <= '0;
    end else if (atEnd) begin
      cnt    <= '0;
      lenReg <= nextLen;
      acc    <= sum[FRAC_W-1:0];
    end else begin
      cnt    <= cnt + LEN_W'(1);
    end
  end

  assign tick = atEnd;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt < lenReg); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cnt == '0)); // R6
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(lenReg)); // R6
endmodule

// File: rtl/baudDatapath.sv
module baudDatapath
  import baudGenPkg::*;
#(
  parameter int RST_UART_INT = 11,
  parameter int RST_IR_INT   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCfg_t cfg,
  output logic    uartTick,
  output logic    irTick
);
  baudChan #(
    .INT_W(UART_INT_W), .MUL_LOG2(UART_MUL_LOG2),
    .FRAC_W(FRAC_W), .RST_INT(RST_UART_INT)
  ) u_uartChan (
    .clk(clk), .rstN(rstN),
    .intVal(cfg.uartInt), .fracVal(cfg.uartFrac),
    .tick(uartTick)
  );

  baudChan #(
    .INT_W(IR_INT_W), .MUL_LOG2(IR_MUL_LOG2),
    .FRAC_W(FRAC_W), .RST_INT(RST_IR_INT)
  ) u_irChan (
    .clk(clk), .rstN(rstN),
    .intVal(cfg.irInt), .fracVal(cfg.irFrac),
    .tick(irTick)
  );
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import baudGenPkg::*;
#(
  parameter int RST_UART_INT = 11,
  parameter int RST_IR_INT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              uartTick,
  output logic              irTick,
  output logic              cfgErr
);
  divCfg_t cfg;

  baudCtrl #(.RST_UART_INT(RST_UART_INT), .RST_IR_INT(RST_IR_INT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .cfgErr(cfgErr)
  );

  baudDatapath #(.RST_UART_INT(RST_UART_INT), .RST_IR_INT(RST_IR_INT)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .uartTick(uartTick), .irTick(irTick)
  );
endmodule

// File: tb/fracBaudGen_tb.sv
module fracBaudGen_tb;
  import baudGenPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic uartTick, irTick, cfgErr;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  int irQ[$];
  int uartQ[$];
  int irAcc = 0;
  int uartAcc = 0;
  int irLast = 0, uartLast = 0;
  bit irHave = 0, uartHave = 0, irPrev = 0, uartPrev = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fracBaudGen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .uartTick(uartTick), .irTick(irTick), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: interval between strobes against queued expected lengths
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      irHave = 0; uartHave = 0; irPrev = 0; uartPrev = 0;
    end else begin
      if (irTick) begin
        chk(!irPrev, "R8 ir strobe width", 2, 1);
        if (irHave && irQ.size() > 0) begin
          int e;
          e = irQ.pop_front();
          chk((cyc - irLast) == e, "R3/R4/R6 ir period", cyc - irLast, e);
        end
        irHave = 1; irLast = cyc;
      end
      if (uartTick) begin
        chk(!uartPrev, "R8 uart strobe width", 2, 1);
        if (uartHave && uartQ.size() > 0) begin
          int e;
          e = uartQ.pop_front();
          chk((cyc - uartLast) == e, "R2/R4/R5 uart period", cyc - uartLast, e);
        end
        uartHave = 1; uartLast = cyc;
      end
      irPrev = irTick;
      uartPrev = uartTick;
    end
  end

  // driver side: expected lengths from the accumulator rule (R4)
  task automatic pushIr(input int base, input int frac, input int n);
    for (int i = 0; i < n; i++) begin
      int s;
      s = irAcc + frac;
      irQ.push_back(base + (s >> 4));
      irAcc = s & 15;
    end
  endtask

  task automatic pushUart(input int base, input int frac, input int n);
    for (int i = 0; i < n; i++) begin
      int s;
      s = uartAcc + frac;
      uartQ.push_back(base + (s >> 4));
      uartAcc = s & 15;
    end
  endtask

  task automatic drainIr();
    do @(posedge clk); while (irQ.size() > 0);
  endtask

  task automatic drainUart();
    do @(posedge clk); while (uartQ.size() > 0);
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic writeReg(input regSel_e a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = DATA_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    irQ.delete(); uartQ.delete();
    irAcc = 0; uartAcc = 0;
    repeat (3) begin
      @(negedge clk);
      chk(irTick == 0 && uartTick == 0, "R1 strobes in reset", int'(irTick) + int'(uartTick), 0);
    end
    chk(cfgErr == 0, "R1 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: default lengths
    doReset();
    pushIr(3, 0, 4);
    pushUart(192, 0, 2);
    drainIr();
    drainUart();
    @(negedge clk);
    chk(cfgErr == 0, "R1 cfgErr after reset", int'(cfgErr), 0);

    // R3 R4: IR N=4, F=5
    doReset();
    writeReg(REG_IR_INT, 4);
    writeReg(REG_IR_FRAC, 16'h0050);
    pushIr(5, 5, 16);
    drainIr();

    // R3 R4: IR minimum count N=1, F=15
    doReset();
    writeReg(REG_IR_INT, 1);
    writeReg(REG_IR_FRAC, 16'h00F0);
    pushIr(2, 15, 16);
    drainIr();

    // R2 R4: UART N=0, F=8
    doReset();
    writeReg(REG_UART_INT, 0);
    writeReg(REG_UART_FRAC, 16'h0080);
    pushUart(16, 8, 6);
    drainUart();

    // R5: fraction low bits ignored (0x3F -> F=3)
    doReset();
    writeReg(REG_UART_INT, 2);
    writeReg(REG_UART_FRAC, 16'h003F);
    pushUart(48, 3, 6);
    drainUart();

    // R7: zero IR count refused, flag sticky
    doReset();
    writeReg(REG_IR_INT, 3);
    pushIr(4, 0, 3);
    drainIr();
    @(negedge clk);
    chk(cfgErr == 0, "R7 flag before zero write", int'(cfgErr), 0);
    writeReg(REG_IR_INT, 0);
    chk(cfgErr == 1, "R7 flag after zero write", int'(cfgErr), 1);
    writeReg(REG_IR_INT, 16'h0010);
    pushIr(4, 0, 4);
    drainIr();
    @(negedge clk);
    chk(cfgErr == 1, "R7 flag sticky", int'(cfgErr), 1);

    // R6: change mid-stream, accumulator continues
    doReset();
    writeReg(REG_IR_INT, 3);
    writeReg(REG_IR_FRAC, 16'h0070);
    pushIr(4, 7, 3);
    drainIr();
    @(negedge clk);
    writeReg(REG_IR_INT, 6);
    pushIr(4, 7, 1);
    pushIr(7, 7, 6);
    drainIr();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule